// File: doc/BRIEF.md
# Floating-Point Compare to Condition Flags

This block compares two single-precision (binary32) floating-point words, a left operand and a right operand, and produces a processor-style four-bit condition result together with an invalid-operation indication. It works straight on the packed encodings. There is no unpacking into a sign/exponent/significand datapath, so the result comes from a few magnitude and equality comparisons on the raw words.

Two control inputs pick the variant. The first, a compare-against-zero select, makes the block ignore the right operand and compare the left operand against positive zero. The second, a signalling-mode select, makes a quiet NaN raise invalid operation as well as a signalling one. Both results are registered, so they appear one clock after the operands are presented.

Top module: `fp_compare_flags`

## Requirements
- R1: While `rst` is high, on the clock edges it covers, `flags_q` clears to 4'b0000 and `invalid_q` clears to 0. In every other cycle both outputs hold the result for the inputs sampled at the previous rising clock edge.
- R2: An operand whose exponent field (bits 30:23) is all ones and whose mantissa field (bits 22:0) is nonzero is a NaN. If either operand is a NaN, the result is unordered and `flags_q` = 4'b0011 (C and V set).
- R3: A NaN with mantissa bit 22 clear is signalling. A signalling NaN on either side sets `invalid_q` in both modes.
- R4: With `sig_mode` = 1, a quiet NaN (mantissa bit 22 set) on either side also sets `invalid_q`. With `sig_mode` = 0, a quiet NaN alone leaves `invalid_q` at 0.
- R5: Two operands that are bit-identical, or that both have zero magnitude in any sign combination (+0 equals -0), give `flags_q` = 4'b0110 (Z and C set).
- R6: For non-NaN operands of differing sign that are not both zero, a negative left operand gives less-than, `flags_q` = 4'b1000 (N set), and a positive left operand gives greater-than, `flags_q` = 4'b0010 (C set).
- R7: For non-NaN operands of equal sign, order follows the magnitudes, with infinities above all finite values and denormals ordered by their encodings. The order is reversed when both are negative. Less-than gives 4'b1000 and greater-than gives 4'b0010.
- R8: With `zero_sel` = 1, the right operand is replaced by +0 (32'h00000000) and `m_word` has no effect on either output, even when it holds a NaN.
- R9: `flags_q` is laid out as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. Out of reset it always holds one of the four codes 4'b0011, 4'b0110, 4'b1000, 4'b0010. No result other than NaN handling sets `invalid_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| d_word | input | 32 | Left operand, binary32 encoding |
| m_word | input | 32 | Right operand, binary32 encoding |
| zero_sel | input | 1 | 1: compare the left operand against +0 |
| sig_mode | input | 1 | 1: signalling compare (quiet NaN also raises invalid) |
| flags_q | output | 4 | Registered condition result {N,Z,C,V} |
| invalid_q | output | 1 | Registered invalid-operation indication |

## Verification
The condition result and the invalid indication are both due exactly one rising clock edge after the operands and mode inputs are presented. Both outputs update on the same edge. The bench changes inputs only on a falling edge, lets one rising edge capture them, and reads both outputs on the next falling edge, so each check reads the result of exactly one stimulus. Directed cases cover signed zeros, both NaN kinds in both modes, infinities, denormals and the zero-compare substitution. They are followed by a few thousand seeded random operand pairs drawn from a pool that favours these special encodings.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  // Condition result layout: bit3 N, bit2 Z, bit1 C, bit0 V
  typedef logic [3:0] nzcv_t;

  localparam nzcv_t CODE_UNORD = 4'b0011;
  localparam nzcv_t CODE_EQUAL = 4'b0110;
  localparam nzcv_t CODE_LESS  = 4'b1000;
  localparam nzcv_t CODE_MORE  = 4'b0010;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] word,
  output logic                 is_nan,
  output logic                 is_snan
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;

  logic exp_ones;
  logic man_nz;

  assign exp_ones = &word[WORD_W-2:MAN_W];
  assign man_nz   = |word[MAN_W-1:0];
  assign is_nan   = exp_ones & man_nz;
  // quiet bit is the top mantissa bit
  assign is_snan  = is_nan & ~word[MAN_W-1];
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] lhs,
  input  logic [WORD_W-1:0] rhs,
  output logic              same,
  output logic              below
);
  logic sign_l;
  logic sign_r;
  logic raw_lt;

  assign sign_l = lhs[WORD_W-1];
  assign sign_r = rhs[WORD_W-1];
  assign raw_lt = lhs < rhs;

  always_comb begin
    same  = (lhs == rhs) || ((lhs[WORD_W-2:0] | rhs[WORD_W-2:0]) == '0);
    below = 1'b0;
    if (!same) begin
      if (sign_l != sign_r) below = sign_l;
      else                  below = sign_l ^ raw_lt;
    end
  end
endmodule

// File: rtl/fp_compare_flags.sv
module fp_compare_flags #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EXP_W+MAN_W:0] d_word,
  input  logic [EXP_W+MAN_W:0] m_word,
  input  logic                 zero_sel,
  input  logic                 sig_mode,
  output logic [3:0]           flags_q,
  output logic                 invalid_q
);
  import fpcmp_pkg::*;

  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int N_OPND = 2;

  logic [WORD_W-1:0] opnd [N_OPND];
  logic [N_OPND-1:0] nan_v;
  logic [N_OPND-1:0] snan_v;
  logic              same;
  logic              below;
  nzcv_t             flags_c;
  logic              invalid_c;

  assign opnd[0] = d_word;
  assign opnd[1] = zero_sel ? '0 : m_word;

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cls_i (
      .word    (opnd[gi]),
      .is_nan  (nan_v[gi]),
      .is_snan (snan_v[gi])
    );
  end

  fpcmp_order #(.WORD_W(WORD_W)) ord_i (
    .lhs   (opnd[0]),
    .rhs   (opnd[1]),
    .same  (same),
    .below (below)
  );

  always_comb begin
    invalid_c = (|snan_v) | (sig_mode & (|nan_v));
    if (|nan_v)     flags_c = CODE_UNORD;
    else if (same)  flags_c = CODE_EQUAL;
    else if (below) flags_c = CODE_LESS;
    else            flags_c = CODE_MORE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      invalid_q <= 1'b0;
    end else begin
      flags_q   <= flags_c;
      invalid_q <= invalid_c;
    end
  end
endmodule

// File: rtl/fp_compare_flags_chk.sv
module fp_compare_flags_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input logic                 clk,
  input logic                 rst,
  input logic [EXP_W+MAN_W:0] d_word,
  input logic [EXP_W+MAN_W:0] m_word,
  input logic                 zero_sel,
  input logic                 sig_mode,
  input logic [3:0]           flags_q,
  input logic                 invalid_q
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;

  logic d_nan, m_nan, d_snan, m_snan, both_zero;

  assign d_nan  = (d_word[WORD_W-2:MAN_W] == '1) && (d_word[MAN_W-1:0] != '0);
  assign m_nan  = !zero_sel && (m_word[WORD_W-2:MAN_W] == '1) && (m_word[MAN_W-1:0] != '0);
  assign d_snan = d_nan && !d_word[MAN_W-1];
  assign m_snan = m_nan && !m_word[MAN_W-1];
  assign both_zero = (d_word[WORD_W-2:0] == '0) && (zero_sel || (m_word[WORD_W-2:0] == '0));

  // R1: first edge after reset shows the cleared state
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flags_q == 4'b0000 && !invalid_q));

  // R2: a NaN on either side yields the unordered code
  a_r2_nan_unordered: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(d_nan || m_nan)) |-> (flags_q == 4'b0011));

  // R3: a signalling NaN always raises invalid
  a_r3_snan_invalid: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(d_snan || m_snan)) |-> invalid_q);

  // R4: signalling mode with a quiet NaN raises invalid
  a_r4_sigmode_qnan: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sig_mode && (d_nan || m_nan))) |-> invalid_q);

  // R5: zeros of any sign compare equal without invalid
  a_r5_zeros_equal: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(both_zero)) |-> (flags_q == 4'b0110 && !invalid_q));

  // R9: only the four legal codes appear, invalid only with a NaN
  a_r9_legal_code: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flags_q == 4'b0011) || (flags_q == 4'b0110) ||
                     (flags_q == 4'b1000) || (flags_q == 4'b0010)));
  a_r9_invalid_needs_nan: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && invalid_q) |-> (flags_q == 4'b0011));
endmodule

bind fp_compare_flags fp_compare_flags_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .d_word    (d_word),
  .m_word    (m_word),
  .zero_sel  (zero_sel),
  .sig_mode  (sig_mode),
  .flags_q   (flags_q),
  .invalid_q (invalid_q)
);

// File: tb/fp_compare_flags_tb_top.sv
`timescale 1ns/1ps
module fp_compare_flags_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] d_word = '0;
  logic [31:0] m_word = '0;
  logic        zero_sel = 1'b0;
  logic        sig_mode = 1'b0;
  logic [3:0]  flags_q;
  logic        invalid_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_compare_flags dut_i (
    .clk(clk), .rst(rst), .d_word(d_word), .m_word(m_word),
    .zero_sel(zero_sel), .sig_mode(sig_mode),
    .flags_q(flags_q), .invalid_q(invalid_q)
  );

  function automatic bit is_nan(input logic [31:0] w);
    return (w[30:23] == 8'hFF) && (w[22:0] != 0);
  endfunction

  // ordering key: larger key means larger value (zeros handled before)
  function automatic logic [32:0] okey(input logic [31:0] w);
    return w[31] ? {2'b00, 31'h7FFFFFFF - w[30:0]} : {2'b01, w[30:0]};
  endfunction

  function automatic logic [4:0] model(input logic [31:0] d, input logic [31:0] m0,
                                       input logic z, input logic s);
    logic [31:0] m;
    logic [3:0]  f;
    logic        inv;
    m = z ? 32'h0 : m0;
    inv = 1'b0;
    if (is_nan(d) || is_nan(m)) begin
      f = 4'b0011;
      if ((is_nan(d) && !d[22]) || (is_nan(m) && !m[22]) || s) inv = 1'b1;
    end else if (d[30:0] == 0 && m[30:0] == 0) f = 4'b0110;
    else if (okey(d) == okey(m)) f = 4'b0110;
    else if (okey(d) < okey(m)) f = 4'b1000;
    else f = 4'b0010;
    return {f, inv};
  endfunction

  task automatic check(input string req, input logic [3:0] ef, input logic ei);
    checks++;
    if (flags_q !== ef || invalid_q !== ei) begin
      errors++;
      $display("FAIL %s d=%h m=%h z=%0b s=%0b: got flags=%b inv=%b expected flags=%b inv=%b",
               req, d_word, m_word, zero_sel, sig_mode, flags_q, invalid_q, ef, ei);
    end
  endtask

  task automatic apply(input string req, input logic [31:0] d, input logic [31:0] m,
                       input logic z, input logic s);
    logic [4:0] e;
    @(negedge clk);
    d_word = d; m_word = m; zero_sel = z; sig_mode = s;
    e = model(d, m, z, s);
    @(negedge clk);
    check(req, e[4:1], e[0]);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] r;
    logic        sg;
    r  = $urandom;
    sg = r[31];
    case ($urandom % 7)
      0: return {sg, 31'h0};
      1: return {sg, 8'hFF, 23'h0};
      2: return {sg, 8'hFF, 1'b1, r[21:0]};
      3: return {sg, 8'hFF, 1'b0, r[21:1], 1'b1};
      4: return {sg, 8'h00, r[22:0]};
      5: return {sg, 8'h7F, r[22:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", 4'b0000, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    // R5 signed zeros and identical words
    apply("R5 +0 vs -0", 32'h00000000, 32'h80000000, 0, 0);
    apply("R5 identical", 32'h3F800000, 32'h3F800000, 0, 1);
    // R6 differing signs
    apply("R6 neg vs pos", 32'hBF800000, 32'h3F800000, 0, 0);
    apply("R6 pos vs neg", 32'h3F800000, 32'hC0000000, 0, 0);
    // R7 equal signs, infinities, denormals
    apply("R7 1 vs 2", 32'h3F800000, 32'h40000000, 0, 0);
    apply("R7 -1 vs -2", 32'hBF800000, 32'hC0000000, 0, 0);
    apply("R7 denormals", 32'h00000001, 32'h00000002, 0, 0);
    apply("R7 neg denormals", 32'h80000001, 32'h80000002, 0, 0);
    apply("R7 inf vs max", 32'h7F800000, 32'h7F7FFFFF, 0, 0);
    apply("R7 -inf vs -inf", 32'hFF800000, 32'hFF800000, 0, 0);
    // R2 / R4 quiet NaN in both modes
    apply("R2 qnan quiet", 32'h7FC00000, 32'h3F800000, 0, 0);
    apply("R4 qnan signalling", 32'h3F800000, 32'hFFC00001, 0, 1);
    // R3 signalling NaN on each side, both modes
    apply("R3 snan d", 32'h7F800001, 32'h3F800000, 0, 0);
    apply("R3 snan m", 32'h00000000, 32'h7FA00000, 0, 1);
    // R8 zero compare ignores m
    apply("R8 zero_sel m nan", 32'h3F800000, 32'h7F800001, 1, 0);
    apply("R8 zero_sel -0", 32'h80000000, 32'h12345678, 1, 0);
    apply("R8 zero_sel neg denorm", 32'h80000005, 32'hFFC00000, 1, 1);
    // R9 layout: N alone set for less-than
    apply("R9 less code", 32'hFF800000, 32'h00000000, 0, 0);
    // R1 latency held across random sequence; R2-R8 randomized
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      a = pick();
      b = ($urandom % 6 == 0) ? a : pick();
      apply("R7 random", a, b, ($urandom % 5) == 0, $urandom % 2);
    end
    // R1 reset clears again
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", 4'b0000, 1'b0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule